// File: doc/BRIEF.md
# Table-Driven Bit-Slice ALU

This block is a purely combinational arithmetic and logic unit built from a row of identical one-bit slices. Each slice holds no fixed operator. It evaluates three small lookup tables of four entries each, and all slices share the same three tables. The first table gives an internal propagate term from the slice's two operand bits. The second gives an internal kill term from the same two bits. The third gives the result bit from the propagate term and the slice's incoming carry.

A ripple chain links the slices. Each slice passes a carry to its more significant neighbour using the rule carry = (P AND carry_in) OR (NOT P AND NOT K). A small decoder turns the operation code into the three table vectors. A new operation therefore needs new table contents, not a new datapath.

The unit is meant to sit inside a larger datapath. There the operands, carry-in and code are held steady, and the result and carry-out are taken once the ripple has settled.

Top module: `fn_slice_alu`

## Requirements
- R1: With op_code 0 the result equals operand a.
- R2: With op_code 1 the result equals operand b.
- R3: With op_code 2 the result equals the bitwise inverse of operand a.
- R4: With op_code 3 the result equals a AND b, bit by bit.
- R5: With op_code 12, {carry_out, result} equals a + b + carry_in as a 9-bit unsigned sum. The carry ripples from bit 0 up to bit 7.
- R6: For op_codes 0 to 3 the kill table is all ones. carry_out is then carry_in AND the AND-reduction of the per-bit propagate terms, which are the logic result bits.
- R7: Any op_code other than 0, 1, 2, 3 and 12 gives a result of zero and a carry_out of zero, whatever the operands and carry_in.
- R8: Table entries are indexed by the bit pair (high, low). For the P and K tables the pair is (a, b). For the result table the pair is (P, carry_in). The index is high*2+low, so entry 0 is (0,0) and entry 3 is (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | First operand |
| b_in | input | 8 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| op_code | input | 4 | Operation select |
| res_out | output | 8 | Result |
| carry_out | output | 1 | Carry out of bit 7 |

## Verification
In every addition, two things happen in the same evaluation. The carry ripples along the slices, and each slice selects its result bit from a carry that depends on the slices below it. The worst case sends a carry from bit 0 all the way to bit 7. The bench provokes this directly with a = 0xFF, b = 0x00 and carry_in = 1, and with a = 0xFF, b = 0x01. Random operands also produce many partial ripples. Each outcome is judged against a 9-bit arithmetic sum that is computed without any tables.

// File: rtl/fn_slice_alu.sv
module fn_slice_alu #(
  parameter int WIDTH = 8,
  parameter int OP_W  = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  input  logic [OP_W-1:0]  op_code,
  output logic [WIDTH-1:0] res_out,
  output logic             carry_out
);
  localparam logic [OP_W-1:0] OP_PASS_A = OP_W'(0);
  localparam logic [OP_W-1:0] OP_PASS_B = OP_W'(1);
  localparam logic [OP_W-1:0] OP_INV_A  = OP_W'(2);
  localparam logic [OP_W-1:0] OP_AND    = OP_W'(3);
  localparam logic [OP_W-1:0] OP_ADD    = OP_W'(12);
  localparam logic [3:0]      RES_IS_P  = 4'b1100;

  logic [3:0] p_tab, k_tab, r_tab;
  logic [WIDTH:0] chain;

  always_comb begin
    p_tab = 4'b0000;
    k_tab = 4'b1111;
    r_tab = 4'b0000;
    case (op_code)
      OP_PASS_A: begin p_tab = 4'b1100; r_tab = RES_IS_P; end
      OP_PASS_B: begin p_tab = 4'b1010; r_tab = RES_IS_P; end
      OP_INV_A:  begin p_tab = 4'b0011; r_tab = RES_IS_P; end
      OP_AND:    begin p_tab = 4'b1000; r_tab = RES_IS_P; end
      OP_ADD:    begin p_tab = 4'b0110; k_tab = 4'b0001; r_tab = 4'b0110; end
      default: ;
    endcase
  end

  assign chain[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic prop, kill;
    assign prop         = p_tab[{a_in[i], b_in[i]}];
    assign kill         = k_tab[{a_in[i], b_in[i]}];
    assign chain[i+1]   = (prop & chain[i]) | (~prop & ~kill);
    assign res_out[i]   = r_tab[{prop, chain[i]}];
  end

  assign carry_out = chain[WIDTH];
endmodule

module fn_slice_alu_chk #(
  parameter int WIDTH = 8,
  parameter int OP_W  = 4
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             carry_in,
  input logic [OP_W-1:0]  op_code,
  input logic [WIDTH-1:0] res_out,
  input logic             carry_out
);
  logic [WIDTH:0] sum_ref;
  assign sum_ref = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (op_code == OP_W'(0)) p_pass_a_r1: assert (res_out == a_in && carry_out == (carry_in & (&a_in)));
    if (op_code == OP_W'(1)) p_pass_b_r2: assert (res_out == b_in);
    if (op_code == OP_W'(2)) p_inv_a_r3: assert (res_out == ~a_in);
    if (op_code == OP_W'(3)) p_and_r4: assert (res_out == (a_in & b_in) && carry_out == (carry_in & (&(a_in & b_in))));
    if (op_code == OP_W'(12)) p_add_r5: assert ({carry_out, res_out} == sum_ref);
    if (!(op_code inside {OP_W'(0), OP_W'(1), OP_W'(2), OP_W'(3), OP_W'(12)}))
      p_unused_zero_r7: assert (res_out == '0 && carry_out == 1'b0);
  end
endmodule

bind fn_slice_alu fn_slice_alu_chk #(.WIDTH(WIDTH), .OP_W(OP_W)) u_chk (.*);

// File: tb/tb_fn_slice_alu.sv
module tb_fn_slice_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic [7:0] a_in, b_in, res_out;
  logic carry_in, carry_out;
  logic [3:0] op_code;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fn_slice_alu dut (.a_in(a_in), .b_in(b_in), .carry_in(carry_in), .op_code(op_code),
                    .res_out(res_out), .carry_out(carry_out));

  function automatic logic [8:0] model(input logic [3:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic ci);
    logic [7:0] v;
    case (op)
      4'd0:  v = a;
      4'd1:  v = b;
      4'd2:  v = ~a;
      4'd3:  v = a & b;
      4'd12: return {1'b0, a} + {1'b0, b} + {8'd0, ci};
      default: return 9'd0;
    endcase
    return {ci & (&v), v};
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1/R6/R8";
      4'd1: return "R2/R6/R8";
      4'd2: return "R3/R6/R8";
      4'd3: return "R4/R6/R8";
      4'd12: return "R5/R8";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic ci);
    logic [8:0] exp;
    @(negedge clk);
    op_code = op; a_in = a; b_in = b; carry_in = ci;
    @(posedge clk);
    #1;
    exp = model(op, a, b, ci);
    checks++;
    if ({carry_out, res_out} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%0b: got cout=%0b res=%h, expected cout=%0b res=%h",
               req_of(op), op, a, b, ci, carry_out, res_out, exp[8], exp[7:0]);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [6];
    void'($urandom(32'd4711));
    ops = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd12, 4'd7};
    op_code = 4'd0; a_in = 8'h00; b_in = 8'h00; carry_in = 1'b0;
    // idle state: all-zero inputs give zero result (R1)
    apply(4'd0, 8'h00, 8'h00, 1'b0);
    // corners per operation
    foreach (ops[i]) begin
      apply(ops[i], 8'h00, 8'h00, 1'b0);
      apply(ops[i], 8'hFF, 8'hFF, 1'b1);
      apply(ops[i], 8'hFF, 8'h00, 1'b1);
      apply(ops[i], 8'h00, 8'hFF, 1'b0);
      apply(ops[i], 8'hA5, 8'h5A, 1'b1);
    end
    // R5 full ripple through all slices
    apply(4'd12, 8'hFF, 8'h01, 1'b0);
    apply(4'd12, 8'h80, 8'h80, 1'b0);
    apply(4'd12, 8'h7F, 8'h00, 1'b1);
    // R6 carry with all-ones propagate
    apply(4'd0, 8'hFF, 8'h12, 1'b1);
    apply(4'd2, 8'h00, 8'h34, 1'b1);
    apply(4'd3, 8'hFE, 8'hFF, 1'b1);
    // R7 every unused code with all-ones operands
    for (int c = 0; c < 16; c++)
      if (!(c inside {0, 1, 2, 3, 12})) apply(4'(c), 8'hFF, 8'hFF, 1'b1);
    // random mix over all codes
    for (int n = 0; n < 2000; n++)
      apply(4'($urandom_range(15)), 8'($urandom), 8'($urandom), 1'($urandom));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule